// File: doc/BRIEF.md
# Phase-Shifted LED Dimming Generator

This block turns one incoming PWM dimming signal into on/off gate signals for up to `NCH` LED current sinks. A single mode input chooses how it does so. In direct mode every enabled sink simply follows the synchronised input, so all strings switch together at the input's frequency and duty. In phase-shift mode the block measures the input's high time and period in system clocks and reduces them to an 8-bit duty code. It then rebuilds that duty at an output period taken from a configuration register, in clock cycles, so the output frequency no longer depends on the input. The start of each active channel's on-window is spread evenly across the period. The spacing is 1/N of the period, where N counts only the channels whose mask bit is set.

A flag reports a 0% duty. The LED boost supply uses it to hold off start-up while the input PWM stays low. When no rising input edge arrives for `TMO` clocks, the duty is forced to 0% or 100%, depending on the level the input is stuck at. The output period, the duty code and the channel mask are all taken up only at the start of an output period, so a configuration write never produces a shortened pulse.

Top module: `pwm_dim_gen`

## Requirements
- R1: During and after synchronous reset, all `ch_en` bits are 0 and `zero_duty` is 1.
- R2: With `mode_phase`=0, `ch_en[i]` equals `ch_mask[i]` AND the value `pwm_in` had three rising clock edges earlier (two synchroniser stages plus the output register).
- R3: At each synchronised input rising edge that closes a period shorter than `TMO` clocks, the duty code becomes floor(255·high/period), with both counted in clocks. In phase mode each active channel is then on for floor(code·P/255) clocks of every output period P.
- R4: With `mode_phase`=1, the outputs repeat with period P = `period_cfg` clocks, independent of the input frequency. Values below `MINP` are raised to `MINP`.
- R5: A change of `period_cfg`, of the duty code or of `ch_mask` affects phase-mode outputs only from the next output period start.
- R6: With N mask bits set, the k-th set bit counted from bit 0 (k = 0..N-1) has its on-window start at floor(k·P/N) clocks after the period start.
- R7: A channel whose mask bit is 0 holds `ch_en` low in both modes.
- R8: If no input rising edge arrives for `TMO` clocks, the duty code becomes 255 (always on) when the synchronised input is high, and 0 when it is low. The first rising edge after such a timeout starts a new measurement without changing the code.
- R9: `zero_duty` is 1 exactly when the current duty code is 0.
- R10: The mode input takes effect at the next output-register update, with no delay for a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM dimming input |
| mode_phase | input | 1 | 0 = direct mode, 1 = phase-shift mode |
| period_cfg | input | CNT_W | Phase-mode output period in clocks |
| ch_mask | input | NCH | Bit i set = channel i in use |
| ch_en | output | NCH | Registered sink enables |
| zero_duty | output | 1 | Registered 0%-duty indicator |

## Verification
The bench builds the block with `NCH`=6, `CNT_W`=12, `TMO`=300 and `MINP`=2. With the timeout at 300 clocks, both stuck-high and stuck-low inputs are reached within a few hundred cycles, as is the ignored first edge after a timeout. Output periods of 30 to 37 clocks let many whole periods, and several mask and period changes in the middle of a period, fit into a short run. Six channels with masks of three and six active bits exercise the uneven floor(k·P/N) slot offsets.

// File: rtl/pwmdim_pkg.sv
package pwmdim_pkg;
  typedef enum logic {DIM_DIRECT = 1'b0, DIM_PHASE = 1'b1} dim_mode_e;
  localparam logic [7:0] DUTY_FULL = 8'hFF;
endpackage

// File: rtl/pwmdim_meas.sv
// Input synchroniser plus duty extraction in clock counts, with idle timeout.
module pwmdim_meas
  import pwmdim_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMO   = 60000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_in,
  output logic       pwm_s,
  output logic [7:0] duty,
  output logic       zero
);
  localparam int PW = CNT_W + 8;
  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TMO);

  logic             s1, s2, prev;
  logic [CNT_W-1:0] per_cnt, hi_cnt;
  logic             rise, timed_out;
  logic [PW-1:0]    prod;
  logic [7:0]       meas_duty;

  assign rise      = s2 & ~prev;
  assign timed_out = per_cnt >= TMO_C;
  assign prod      = PW'(hi_cnt) * PW'(DUTY_FULL);
  assign meas_duty = (per_cnt == '0) ? 8'd0 : 8'(prod / PW'(per_cnt));
  assign pwm_s     = s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      prev    <= 1'b0;
      per_cnt <= TMO_C;     // start in the timed-out state: first edge only arms
      hi_cnt  <= '0;
      duty    <= '0;
      zero    <= 1'b1;
    end else begin
      s1   <= pwm_in;
      s2   <= s1;
      prev <= s2;
      if (rise) begin
        if (!timed_out) begin
          duty <= meas_duty;
          zero <= (meas_duty == 8'd0);
        end
        per_cnt <= CNT_W'(1);
        hi_cnt  <= CNT_W'(1);
      end else if (timed_out) begin
        duty <= s2 ? DUTY_FULL : 8'd0;
        zero <= ~s2;
      end else begin
        per_cnt <= per_cnt + CNT_W'(1);
        hi_cnt  <= hi_cnt + CNT_W'(s2);
      end
    end
  end
endmodule

// File: rtl/pwmdim_slots.sv
// Slot offset per channel: rank among active channels times period over count.
module pwmdim_slots #(
  parameter int NCH   = 6,
  parameter int CNT_W = 16
) (
  input  logic [NCH-1:0]   mask,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] offs [NCH]
);
  localparam int SW = $clog2(NCH + 1);
  localparam int NW = CNT_W + SW;

  logic [SW-1:0] n_act;

  always_comb begin
    n_act = '0;
    for (int i = 0; i < NCH; i++) n_act += SW'(mask[i]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic [SW-1:0] rank;
    logic [NW-1:0] num;
    always_comb begin
      rank = '0;
      for (int j = 0; j < g; j++) rank += SW'(mask[j]);
    end
    assign num     = NW'(rank) * NW'(period);
    assign offs[g] = (n_act == '0) ? '0 : CNT_W'(num / NW'(n_act));
  end
endmodule

// File: rtl/pwmdim_phase.sv
// Output period counter; latches period, on-time, mask and offsets at wrap.
module pwmdim_phase
  import pwmdim_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int CNT_W = 16,
  parameter int MINP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [7:0]       duty,
  input  logic [NCH-1:0]   mask,
  output logic [NCH-1:0]   on_vec,
  output logic [NCH-1:0]   mask_l
);
  localparam int PW = CNT_W + 8;

  logic [CNT_W-1:0] per_new, per_l, oc, on_l;
  logic [CNT_W-1:0] off_new [NCH];
  logic [CNT_W-1:0] off_l   [NCH];
  logic [PW-1:0]    on_prod;
  logic             wrap;

  assign per_new = (period_cfg < CNT_W'(MINP)) ? CNT_W'(MINP) : period_cfg;
  assign wrap    = oc >= (per_l - CNT_W'(1));
  assign on_prod = PW'(duty) * PW'(per_new);

  pwmdim_slots #(.NCH(NCH), .CNT_W(CNT_W)) u_slots (
    .mask   (mask),
    .period (per_new),
    .offs   (off_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oc     <= '0;
      per_l  <= CNT_W'(1);   // forces a wrap (and first latch) on the first edge
      on_l   <= '0;
      mask_l <= '0;
      for (int i = 0; i < NCH; i++) off_l[i] <= '0;
    end else if (wrap) begin
      oc     <= '0;
      per_l  <= per_new;
      on_l   <= CNT_W'(on_prod / PW'(DUTY_FULL));
      mask_l <= mask;
      off_l  <= off_new;
    end else begin
      oc <= oc + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    logic [CNT_W-1:0] rel;
    assign rel       = (oc >= off_l[g]) ? (oc - off_l[g]) : (oc + per_l - off_l[g]);
    assign on_vec[g] = rel < on_l;
  end
endmodule

// File: rtl/pwm_dim_gen.sv
module pwm_dim_gen
  import pwmdim_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int CNT_W = 16,
  parameter int TMO   = 60000,
  parameter int MINP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_in,
  input  logic             mode_phase,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [NCH-1:0]   ch_mask,
  output logic [NCH-1:0]   ch_en,
  output logic             zero_duty
);
  logic             pwm_s;
  logic [7:0]       duty;
  logic [NCH-1:0]   on_vec, mask_l;

  pwmdim_meas #(.CNT_W(CNT_W), .TMO(TMO)) u_meas (
    .clk    (clk),
    .rst    (rst),
    .pwm_in (pwm_in),
    .pwm_s  (pwm_s),
    .duty   (duty),
    .zero   (zero_duty)
  );

  pwmdim_phase #(.NCH(NCH), .CNT_W(CNT_W), .MINP(MINP)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .period_cfg (period_cfg),
    .duty       (duty),
    .mask       (ch_mask),
    .on_vec     (on_vec),
    .mask_l     (mask_l)
  );

  always_ff @(posedge clk) begin
    if (rst) ch_en <= '0;
    else if (dim_mode_e'(mode_phase) == DIM_PHASE) ch_en <= mask_l & on_vec;
    else ch_en <= ch_mask & {NCH{pwm_s}};
  end
endmodule

// File: rtl/pwm_dim_gen_chk.sv
module pwm_dim_gen_chk #(
  parameter int NCH = 6,
  parameter int TMO = 60000
) (
  input logic           clk,
  input logic           rst,
  input logic           pwm_in,
  input logic           mode_phase,
  input logic [NCH-1:0] ch_mask,
  input logic [NCH-1:0] ch_en,
  input logic           zero_duty
);
  localparam int LIM = TMO + 4;

  logic       rst_q;
  logic [1:0] since;
  int         lo_run, hi_run;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      since  <= '0;
      lo_run <= 0;
      hi_run <= 0;
    end else begin
      if (since != 2'd3) since <= since + 2'd1;
      if (pwm_in) begin
        hi_run <= (hi_run < LIM) ? hi_run + 1 : hi_run;
        lo_run <= 0;
      end else begin
        lo_run <= (lo_run < LIM) ? lo_run + 1 : lo_run;
        hi_run <= 0;
      end
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (ch_en == '0 && zero_duty));

  a_r2_direct_follow: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && !$past(mode_phase)) |->
      (ch_en == ($past(ch_mask) & {NCH{$past(pwm_in, 3)}})));

  a_r7_masked_low: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_phase) |-> ((ch_en & ~$past(ch_mask)) == '0));

  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    (lo_run >= LIM) |-> zero_duty);

  a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
    (hi_run >= LIM) |-> !zero_duty);
endmodule

bind pwm_dim_gen pwm_dim_gen_chk #(.NCH(NCH), .TMO(TMO)) i_chk (.*);

// File: tb/test_pwm_dim_gen.sv
`timescale 1ns/1ps
module test_pwm_dim_gen;
  localparam int NCH = 6, CNT_W = 12, TMO = 300, MINP = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pwm_in = 1'b0;
  logic             mode_phase = 1'b0;
  logic [CNT_W-1:0] period_cfg = CNT_W'(30);
  logic [NCH-1:0]   ch_mask = '0;
  logic [NCH-1:0]   ch_en;
  logic             zero_duty;

  int    checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit    started = 0, done = 0;

  always #2.5 clk = ~clk;

  pwm_dim_gen #(.NCH(NCH), .CNT_W(CNT_W), .TMO(TMO), .MINP(MINP)) i_pwm_dim_gen (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .mode_phase(mode_phase),
    .period_cfg(period_cfg), .ch_mask(ch_mask), .ch_en(ch_en), .zero_duty(zero_duty)
  );

  // Input PWM source: forced level or periodic waveform, driven after negedge.
  int pw_per = 40, pw_hi = 10, pw_cnt = 0, pw_force = 0;
  always @(negedge clk) begin
    #1;
    if (pw_force >= 0) pwm_in = pw_force[0];
    else begin
      pwm_in = (pw_cnt < pw_hi);
      pw_cnt = (pw_cnt + 1 >= pw_per) ? 0 : pw_cnt + 1;
    end
  end

  // Behavioural reference, evaluated on every rising edge.
  int h0, h1, mprev, mper, mhi, mduty, mzero, moc, mpl, mon;
  int moff [NCH];
  logic [NCH-1:0] mmask, exp_ch;
  bit exp_zero;

  always @(posedge clk) begin
    if (rst) begin
      h0 = 0; h1 = 0; mprev = 0; mper = TMO; mhi = 0; mduty = 0; mzero = 1;
      moc = 0; mpl = 1; mon = 0; mmask = '0; exp_ch = '0; exp_zero = 1;
      for (int i = 0; i < NCH; i++) moff[i] = 0;
      started = 1;
    end else begin
      int p, n, rank, rel, d;
      logic [NCH-1:0] onv;
      for (int i = 0; i < NCH; i++) begin
        rel = (moc >= moff[i]) ? moc - moff[i] : moc + mpl - moff[i];
        onv[i] = (rel < mon);
      end
      exp_ch = mode_phase ? (mmask & onv) : (ch_mask & {NCH{h1[0]}});
      if (moc >= mpl - 1) begin
        p = (int'(period_cfg) < MINP) ? MINP : int'(period_cfg);
        moc = 0; mpl = p; mon = mduty * p / 255; mmask = ch_mask;
        n = 0;
        for (int i = 0; i < NCH; i++) n += ch_mask[i];
        rank = 0;
        for (int i = 0; i < NCH; i++) begin
          moff[i] = (n == 0) ? 0 : rank * p / n;
          rank += ch_mask[i];
        end
      end else moc++;
      if (h1 == 1 && mprev == 0) begin
        if (mper < TMO) begin
          d = mhi * 255 / mper; mduty = d; mzero = (d == 0);
        end
        mper = 1; mhi = 1;
      end else if (mper >= TMO) begin
        mduty = h1 ? 255 : 0; mzero = (h1 == 0);
      end else begin
        mper++; mhi += h1;
      end
      exp_zero = mzero;
      mprev = h1; h1 = h0; h0 = int'(pwm_in);
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (ch_en !== exp_ch || zero_duty !== exp_zero) begin
        fails++;
        $display("FAIL %s cycle compare: ch_en=%b zero=%b expected ch_en=%b zero=%b at %0t",
                 cur_req, ch_en, zero_duty, exp_ch, exp_zero, $time);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(int idx, int len, output int cnt);
    cnt = 0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      cnt += ch_en[idx];
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int cnt, t1, t3, t5;
    logic [NCH-1:0] last;
    run(4);
    @(negedge clk); #1 rst = 1'b0;
    // R1: reset values visible at the ports
    @(negedge clk);
    chk("R1 ch_en after reset", int'(ch_en), 0);
    chk("R1 zero_duty after reset", int'(zero_duty), 1);

    // R2 / R7: direct mode follows the input, masked channels stay low
    cur_req = "R2";
    @(negedge clk); #1 ch_mask = 6'h3F; pw_per = 17; pw_hi = 5; pw_force = -1;
    run(100);
    cur_req = "R7";
    #1 ch_mask = 6'h25;
    run(60);

    // R3 / R4: phase mode, duty floor(10*255/40)=63, P=30 -> on 7
    cur_req = "R3";
    #1 mode_phase = 1'b1; ch_mask = 6'h3F; period_cfg = CNT_W'(30);
    pw_per = 40; pw_hi = 10;
    run(300);
    count_high(0, 30, cnt); chk("R3 ch0 on-time per period", cnt, 7);
    count_high(5, 30, cnt); chk("R3 ch5 on-time per period", cnt, 7);

    // R4: input frequency change does not move the output period (duty kept 25%)
    cur_req = "R4";
    #1 pw_per = 24; pw_hi = 6;   // duty floor(6*255/24)=63
    run(200);
    count_high(2, 30, cnt); chk("R4 on-time unchanged by input frequency", cnt, 7);

    // R5: period change mid-period, picked up at next wrap
    cur_req = "R5";
    repeat (13) @(negedge clk);
    #1 period_cfg = CNT_W'(37);
    run(200);
    count_high(1, 37, cnt); chk("R5 on-time after period change", cnt, 63 * 37 / 255);

    // R6: three active channels (bits 1,3,5), P=36 -> offsets 0,12,24, on 8
    cur_req = "R6";
    #1 period_cfg = CNT_W'(36); ch_mask = 6'b101010;
    run(200);
    t1 = -1; t3 = -1; t5 = -1; last = ch_en;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (ch_en[1] && !last[1] && t1 < 0) t1 = c;
      if (ch_en[3] && !last[3] && t3 < 0) t3 = c;
      if (ch_en[5] && !last[5] && t5 < 0) t5 = c;
      last = ch_en;
    end
    chk("R6 slot1 offset", (t3 - t1 + 72) % 36, 12);
    chk("R6 slot2 offset", (t5 - t1 + 72) % 36, 24);
    count_high(0, 36, cnt); chk("R7 unmasked ch0 in phase mode", cnt, 0);
    count_high(3, 36, cnt); chk("R6 slot on-time", cnt, 8);

    // R4: period below minimum is raised
    cur_req = "R4";
    #1 period_cfg = CNT_W'(1);
    run(80);
    #1 period_cfg = CNT_W'(30);
    run(80);

    // R8 / R9: stuck high -> 100%, stuck low -> 0%
    cur_req = "R8";
    #1 ch_mask = 6'h3F; pw_force = 1;
    run(400);
    chk("R8 stuck-high outputs all on", int'(ch_en), 63);
    chk("R9 zero flag low at 100%", int'(zero_duty), 0);
    #1 pw_force = 0;
    run(400);
    chk("R8 stuck-low outputs all off", int'(ch_en), 0);
    chk("R9 zero flag high at 0%", int'(zero_duty), 1);

    // R8: first edge after timeout only arms the measurement
    cur_req = "R8";
    #1 pw_per = 40; pw_hi = 20; pw_cnt = 0; pw_force = -1;
    run(30);
    chk("R9 zero flag held after first edge", int'(zero_duty), 1);
    run(150);
    chk("R9 zero flag cleared after full period", int'(zero_duty), 0);

    // R10: mode switches back to direct immediately
    cur_req = "R10";
    #1 mode_phase = 1'b0;
    run(60);
    #1 mode_phase = 1'b1;
    run(60);

    done = 1;
    summary();
    $finish;
  end
endmodule